// File: doc/BRIEF.md
# Over-Voltage Fault Handler with Selectable Recovery

This block guards a switching regulator against output over-voltage. Each clock it compares a digitised output-voltage code with a trip level derived from the target code and a 2-bit select. An excursion above the trip level becomes a fault only after it has lasted an unbroken qualification window. On a fault the block drops the high-side enable at once, forces power-good low and keeps the low-side switch on to discharge the inductor. When the zero-crossing flag reports that the inductor current has reached zero, it tri-states both switches.

Recovery follows the mode bit. In automatic mode (bit = 1) the power-good override is released once the output falls below 102.5 % of the target. Switching resumes once the output falls below the target itself. In latched mode (bit = 0) the high side stays off until the active-low enable/supply reset is applied. In that mode the low side is also released as soon as the output is back at or below the trip level, so that negative inductor current cannot build up.

All pins are plain control and status levels, sampled or driven on every clock. There is no data stream and no handshake. The mode bit and the select are treated as static configuration while a fault is in progress.

Top module: `ovp_guard`

## Requirements
- R1: While and after reset (rst_n low), the outputs are hs_en=1, ls_en=1, sw_tristate=0 and pg_pull_low=0.
- R2: The trip level is T + ((T*K)>>8), where T is ref_code. K is 13, 26, 38 or 51 for trip_sel 00, 01, 10 or 11 (about 105/110/115/120 %). The output is over only when out_code is strictly greater than the trip level.
- R3: A fault is declared on the clock edge at which out_code has been over for QUAL_CYC consecutive sampled edges, where QUAL_CYC = CLK_MHZ*QUAL_NS/1000. Any edge at which it is not over restarts the count from zero.
- R4: Starting from the edge that declares the fault, the outputs are hs_en=0, ls_en=1, sw_tristate=0 and pg_pull_low=1.
- R5: While discharging, an edge that samples zero_cross=1 leads to hs_en=0, ls_en=0 and sw_tristate=1. Without that edge, and with auto_mode=1, the discharge outputs hold.
- R6: In auto mode, once tri-stated, an edge that samples out_code < ref_code restores hs_en=1, ls_en=1 and sw_tristate=0.
- R7: In auto mode, after a fault, an edge that samples out_code < T + ((T*6)>>8) releases pg_pull_low to 0. Until then pg_pull_low stays 1.
- R8: In latched mode, hs_en stays 0 and pg_pull_low stays 1 after a fault, whatever out_code does, until rst_n is pulled low.
- R9: In latched mode, while discharging, an edge that samples out_code not over the trip level sets ls_en=0 and sw_tristate=1 without waiting for zero_cross.
- R10: In auto mode, if zero_cross=1 and out_code < ref_code are sampled on the same edge during discharge, the block tri-states first. Switching resumes one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low enable/supply reset, asynchronous |
| out_code | input | VW | Digitised output voltage |
| ref_code | input | VW | Target output voltage code |
| trip_sel | input | 2 | Trip level select |
| auto_mode | input | 1 | 1 = automatic recovery, 0 = latched shutdown |
| zero_cross | input | 1 | Inductor current has reached zero |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| sw_tristate | output | 1 | Request to tri-state both switches |
| pg_pull_low | output | 1 | Forces power-good low |

## Verification
Two recovery conditions can arrive on the same edge: the zero-crossing report that ends the discharge, and the output already below the target that would end the tri-state phase. The bench drives both in one cycle during an automatic-mode discharge. It then expects exactly one cycle of tri-state before switching resumes, with power-good released on the first of those edges. A second case applies the latched-mode drop below the trip level while zero-crossing is low. The bench confirms that the low side is released without it.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_DISCH, ST_TRIS} ovp_state_t;

  // Fixed-point gain in 1/256 steps above unity for each trip select
  function automatic logic [5:0] ov_kfac(input logic [1:0] s);
    case (s)
      2'd0:    return 6'd13;
      2'd1:    return 6'd26;
      2'd2:    return 6'd38;
      default: return 6'd51;
    endcase
  endfunction

  localparam logic [5:0] PG_KFAC = 6'd6;
endpackage

// File: rtl/ovp_levels.sv
module ovp_levels #(
  parameter int VW = 10
) (
  input  logic [VW-1:0] ref_code,
  input  logic [1:0]    trip_sel,
  output logic [VW:0]   trip_lvl,
  output logic [VW:0]   pgrel_lvl
);
  import ovp_pkg::*;

  localparam int NLVL = 4;
  localparam int AW   = VW + 6;

  function automatic logic [VW:0] scale(input logic [VW-1:0] t, input logic [5:0] k);
    logic [AW-1:0] acc;
    acc = '0;
    for (int b = 0; b < 6; b++)
      if (k[b]) acc = acc + (AW'(t) << b);
    return {1'b0, t} + (VW+1)'(acc >> 8);
  endfunction

  logic [VW:0] lvl [NLVL];

  genvar g;
  generate
    for (g = 0; g < NLVL; g++) begin : g_lvl
      localparam logic [5:0] KF = ov_kfac(2'(g));
      assign lvl[g] = scale(ref_code, KF);
    end
  endgenerate

  assign trip_lvl  = lvl[trip_sel];
  assign pgrel_lvl = scale(ref_code, PG_KFAC);
endmodule

// File: rtl/ovp_qual.sv
module ovp_qual #(
  parameter int VW       = 10,
  parameter int QUAL_CYC = 700
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [VW-1:0] out_code,
  input  logic [VW:0]   trip_lvl,
  output logic          over,
  output logic          fault
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] cnt;

  assign over  = {1'b0, out_code} > trip_lvl;
  assign fault = arm && over && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!arm || !over)
      cnt <= '0;
    else if (cnt != LAST)
      cnt <= cnt + 1'b1;
  end

  // R3
  fault_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(over));
endmodule

// File: rtl/ovp_fsm.sv
module ovp_fsm #(
  parameter int VW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic          over,
  input  logic [VW-1:0] out_code,
  input  logic [VW-1:0] ref_code,
  input  logic [VW:0]   pgrel_lvl,
  input  logic          auto_mode,
  input  logic          zero_cross,
  output logic          arm,
  output logic          hs_en,
  output logic          ls_en,
  output logic          sw_tristate,
  output logic          pg_pull_low
);
  import ovp_pkg::*;

  ovp_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    case (st)
      ST_RUN:   if (fault) st_nx = ST_DISCH;
      ST_DISCH: if (zero_cross || (!auto_mode && !over)) st_nx = ST_TRIS;
      ST_TRIS:  if (auto_mode && (out_code < ref_code)) st_nx = ST_RUN;
      default:  st_nx = ST_TRIS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_RUN;
      pg_pull_low <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == ST_RUN && fault)
        pg_pull_low <= 1'b1;
      else if (pg_pull_low && auto_mode && ({1'b0, out_code} < pgrel_lvl))
        pg_pull_low <= 1'b0;
    end
  end

  assign arm         = (st == ST_RUN);
  assign hs_en       = (st == ST_RUN);
  assign ls_en       = (st != ST_TRIS);
  assign sw_tristate = (st == ST_TRIS);

  // R4
  fault_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && fault) |=> (!hs_en && ls_en && pg_pull_low));
  // R5
  zc_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DISCH && zero_cross) |=> sw_tristate);
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_tristate && !auto_mode) |=> (!hs_en && pg_pull_low));
  // R9
  latch_ls_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DISCH && !auto_mode && !over) |=> !ls_en);
  // R7
  pg_before_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> !pg_pull_low);
endmodule

// File: rtl/ovp_guard.sv
module ovp_guard #(
  parameter int VW      = 10,
  parameter int CLK_MHZ = 100,
  parameter int QUAL_NS = 7000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] out_code,
  input  logic [VW-1:0] ref_code,
  input  logic [1:0]    trip_sel,
  input  logic          auto_mode,
  input  logic          zero_cross,
  output logic          hs_en,
  output logic          ls_en,
  output logic          sw_tristate,
  output logic          pg_pull_low
);
  localparam int QUAL_CYC = (CLK_MHZ * QUAL_NS) / 1000;

  logic [VW:0] trip_lvl, pgrel_lvl;
  logic        over, fault, arm;

  ovp_levels #(.VW(VW)) u_levels (
    .ref_code (ref_code),
    .trip_sel (trip_sel),
    .trip_lvl (trip_lvl),
    .pgrel_lvl(pgrel_lvl)
  );

  ovp_qual #(.VW(VW), .QUAL_CYC(QUAL_CYC)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .out_code(out_code),
    .trip_lvl(trip_lvl),
    .over    (over),
    .fault   (fault)
  );

  ovp_fsm #(.VW(VW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault      (fault),
    .over       (over),
    .out_code   (out_code),
    .ref_code   (ref_code),
    .pgrel_lvl  (pgrel_lvl),
    .auto_mode  (auto_mode),
    .zero_cross (zero_cross),
    .arm        (arm),
    .hs_en      (hs_en),
    .ls_en      (ls_en),
    .sw_tristate(sw_tristate),
    .pg_pull_low(pg_pull_low)
  );
endmodule

// File: tb/ovp_guard_bench.sv
module ovp_guard_bench;
  localparam int VW = 10;
  localparam int QC = 10;  // 100 MHz * 100 ns

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VW-1:0] out_code = '0, ref_code = 10'd400;
  logic [1:0] trip_sel = 2'd3;
  logic auto_mode = 1'b1, zero_cross = 1'b0;
  logic hs_en, ls_en, sw_tristate, pg_pull_low;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ovp_guard #(.VW(VW), .CLK_MHZ(100), .QUAL_NS(100)) u_ovp_guard (
    .clk(clk), .rst_n(rst_n), .out_code(out_code), .ref_code(ref_code),
    .trip_sel(trip_sel), .auto_mode(auto_mode), .zero_cross(zero_cross),
    .hs_en(hs_en), .ls_en(ls_en), .sw_tristate(sw_tristate), .pg_pull_low(pg_pull_low)
  );

  localparam logic [3:0] O_RUN = 4'b1100, O_DIS = 4'b0101;
  localparam logic [3:0] O_TRP = 4'b0011, O_TRR = 4'b0010;

  // {sel[15:14], ref[13:4], add_one[3], pad[2:1], expect_fault[0]}
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {2'd0, 10'd400, 1'b1, 2'b0, 1'b1}, {2'd0, 10'd400, 1'b0, 2'b0, 1'b0},
    {2'd1, 10'd300, 1'b1, 2'b0, 1'b1}, {2'd1, 10'd300, 1'b0, 2'b0, 1'b0},
    {2'd2, 10'd500, 1'b1, 2'b0, 1'b1}, {2'd2, 10'd500, 1'b0, 2'b0, 1'b0},
    {2'd3, 10'd800, 1'b1, 2'b0, 1'b1}, {2'd3, 10'd800, 1'b0, 2'b0, 1'b0}
  };

  function automatic int kf(input int s);
    case (s) 0: return 13; 1: return 26; 2: return 38; default: return 51; endcase
  endfunction
  function automatic int trip(input int t, input int s);
    return t + ((t * kf(s)) >> 8);
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs_en, ls_en, sw_tristate, pg_pull_low};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got hs/ls/tri/pg=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; zero_cross = 1'b0; out_code = ref_code;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic trip_now(input int s, input int t);
    trip_sel = 2'(s); ref_code = 10'(t);
    out_code = 10'(trip(t, s) + 1);
    step(QC);
  endtask

  initial begin
    out_code = 10'd400;
    step(1);
    chk("R1 during reset", O_RUN);
    rst_n = 1'b1;
    step(2);
    chk("R1 after reset", O_RUN);

    // R2 vector walk
    for (int i = 0; i < NV; i++) begin
      do_reset();
      auto_mode = 1'b1;
      trip_sel = VEC[i][15:14]; ref_code = VEC[i][13:4];
      out_code = 10'(trip(int'(VEC[i][13:4]), int'(VEC[i][15:14])) + (VEC[i][3] ? 1 : 0));
      step(QC);
      chk($sformatf("R2 vector %0d", i), VEC[i][0] ? O_DIS : O_RUN);
    end

    // R3 qualification and counter restart
    do_reset();
    trip_sel = 2'd3; ref_code = 10'd400;
    out_code = 10'd480; step(QC - 1);
    chk("R3 one short of window", O_RUN);
    out_code = 10'd479; step(1);
    chk("R3 at trip level not over", O_RUN);
    out_code = 10'd480; step(QC - 1);
    chk("R3 count restarted", O_RUN);
    step(1);
    chk("R4 fault outputs", O_DIS);
    step(3);
    chk("R5 no zero cross holds discharge", O_DIS);
    out_code = 10'd470; step(2);
    chk("R9 contrast auto mode keeps low side", O_DIS);
    out_code = 10'd480;
    zero_cross = 1'b1; step(1); zero_cross = 1'b0;
    chk("R5 zero cross tri-states", O_TRP);
    out_code = 10'd420; step(1);
    chk("R7 above release level", O_TRP);
    out_code = 10'd405; step(1);
    chk("R7 below release level", O_TRR);
    out_code = 10'd399; step(1);
    chk("R6 resume below reference", O_RUN);

    // R10 zero cross and below reference on the same edge
    do_reset();
    trip_now(3, 400);
    chk("R10 fault entry", O_DIS);
    zero_cross = 1'b1; out_code = 10'd390; step(1); zero_cross = 1'b0;
    chk("R10 first edge tri-state", O_TRR);
    step(1);
    chk("R10 second edge resume", O_RUN);

    // R8 latched shutdown
    do_reset();
    auto_mode = 1'b0;
    trip_now(1, 300);
    chk("R8 fault entry latched", O_DIS);
    zero_cross = 1'b1; step(1); zero_cross = 1'b0;
    chk("R8 tri-stated", O_TRP);
    out_code = 10'd0; step(20);
    chk("R8 stays off low output", O_TRP);
    do_reset();
    chk("R8 reset clears latch", O_RUN);

    // R9 latched low-side release without zero cross
    trip_now(3, 400);
    chk("R9 fault entry", O_DIS);
    out_code = 10'd479; step(1);
    chk("R9 low side off at trip level", O_TRP);
    step(5);
    chk("R9 stays latched", O_TRP);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule